// File: doc/BRIEF.md
# Two-Lane Programmable Parity Stage

This stage sits between a FIFO's data ports and its storage array. It treats each 18-bit word as two 9-bit lanes. Each lane holds 8 data bits and one parity position. A 3-bit mode chooses one of three behaviours: parity off, parity generated on the write path, or parity checked on the read path. The mode also chooses even or odd sense.

The mode is loaded only while the FIFO's master reset is held. A write made during master reset is a programming write. It copies the top three data bits into the mode register and is not forwarded to storage. If master reset begins without a programming write, the mode returns to off. In that case words pass through untouched in both directions. A read made during master reset returns the stored mode instead of storage data. When no read is made, the read output holds its last value.

Top module: `dual_lane_parity`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, the mode is off, and `wr_en_o`, `rd_data_o` and `rd_err_o` are all zero.
- R2: When `mreset_i` and `wr_en_i` are both high at a clock edge, bits 17:15 of `wr_data_i` are stored as the mode. Bit 17 enables parity, bit 16 selects check (1) or generate (0), and bit 15 selects odd (1) or even (0). While `mreset_i` is high, `wr_en_o` stays low at the next edge.
- R3: On the first clock edge of a master reset period without a programming write, the mode is cleared to off.
- R4: With the mode off, or in check mode, a write outside master reset appears one cycle later on `wr_data_o` unchanged, with `wr_en_o` high. With the mode off, a read outside master reset loads `rd_data_i` into `rd_data_o` unchanged, and `rd_err_o` is 00.
- R5: In generate mode, a write replaces bit 8 with the parity of bits 7:0 and bit 17 with the parity of bits 16:9. All other bits pass unchanged, one cycle later.
- R6: In check mode, a read loads `rd_data_i` unchanged into `rd_data_o`. At the same edge, bit 0 of `rd_err_o` flags a parity mismatch on bits 8:0 and bit 1 flags one on bits 17:9. In generate mode, reads report no error.
- R7: Even sense means that the data bits and the parity bit of a lane XOR to 0. Odd sense means they XOR to 1. This applies to both generation and checking.
- R8: A read with `mreset_i` high loads `rd_data_o` with the mode in bits 17:15 and zeros elsewhere, and clears `rd_err_o`.
- R9: Outside master reset, a cycle without `rd_en_i` leaves `rd_data_o` and `rd_err_o` unchanged.
- R10: The first edge of a master reset period clears `rd_data_o` and `rd_err_o`, unless a programming read happens at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreset_i | input | 1 | FIFO master reset held (active high) |
| wr_en_i | input | 1 | Write request from the FIFO's input side |
| wr_data_i | input | 18 | Word to be written |
| wr_en_o | output | 1 | Write strobe to storage |
| wr_data_o | output | 18 | Word to storage, parity inserted in generate mode |
| rd_en_i | input | 1 | Read request |
| rd_data_i | input | 18 | Word presented by storage |
| rd_data_o | output | 18 | Read result or programming readback |
| rd_err_o | output | 2 | Per-lane parity mismatch, bit 0 for the low lane |

## Verification
The hardest case to reach is a second master reset that carries no programming write. It must drop a mode that was loaded earlier, and this is only visible afterwards through the data. The bench first programs check mode with odd sense. It then runs a bare master reset and reads a word with wrong parity. The error output must stay clear, and a programming read must return zeros. The bench also sets each lane's mismatch alone, by flipping one data bit of one lane. This shows that the two error bits are not swapped.

// File: rtl/dual_lane_parity_pkg.sv
package dual_lane_parity_pkg;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic en;   // parity active
    logic chk;  // 1: check on read, 0: generate on write
    logic odd;  // 1: odd sense, 0: even sense
  } mode_t;
endpackage

// File: rtl/dlp_mode_reg.sv
module dlp_mode_reg
  import dual_lane_parity_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreset_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output mode_t             mode_o,
  output logic              mr_first_o
);
  logic  mr_q;
  mode_t mode_q, mode_n;
  logic  mode_ld;

  assign mr_first_o = mreset_i & ~mr_q;

  always_comb begin
    mode_ld = mreset_i & (wr_en_i | mr_first_o);
    mode_n  = '0;
    if (wr_en_i) mode_n = mode_t'(wr_data_i[WORD_W-1 -: MODE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q   <= 1'b0;
      mode_q <= '0;
    end else begin
      mr_q <= mreset_i;
      if (mode_ld) mode_q <= mode_n;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/dlp_wr_stage.sv
module dlp_wr_stage
  import dual_lane_parity_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DATA_W = 8,
  localparam int LANE_W = DATA_W + 1,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode_i,
  input  logic              mreset_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_data_o
);
  logic [LANES-1:0]  par;
  logic [WORD_W-1:0] word_n;
  logic              vld_n;
  logic              gen;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign par[l] = ^wr_data_i[l*LANE_W +: DATA_W] ^ mode_i.odd;
  end

  always_comb begin
    gen    = mode_i.en & ~mode_i.chk;
    vld_n  = wr_en_i & ~mreset_i;
    word_n = wr_data_i;
    if (gen) begin
      for (int l = 0; l < LANES; l++) word_n[l*LANE_W + DATA_W] = par[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= vld_n;
      if (vld_n) wr_data_o <= word_n;
    end
  end
endmodule

// File: rtl/dlp_rd_stage.sv
module dlp_rd_stage
  import dual_lane_parity_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DATA_W = 8,
  localparam int LANE_W = DATA_W + 1,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode_i,
  input  logic              mreset_i,
  input  logic              mr_first_i,
  input  logic              rd_en_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [LANES-1:0]  rd_err_o
);
  logic [LANES-1:0]  mism;
  logic [WORD_W-1:0] data_n;
  logic [LANES-1:0]  err_n;
  logic              ld;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mism[l] = ^rd_data_i[l*LANE_W +: LANE_W] ^ mode_i.odd;
  end

  always_comb begin
    ld     = 1'b0;
    data_n = '0;
    err_n  = '0;
    if (mreset_i) begin
      ld = rd_en_i | mr_first_i;
      if (rd_en_i) data_n[WORD_W-1 -: MODE_W] = mode_i;
    end else if (rd_en_i) begin
      ld     = 1'b1;
      data_n = rd_data_i;
      if (mode_i.en && mode_i.chk) err_n = mism;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
      rd_err_o  <= '0;
    end else if (ld) begin
      rd_data_o <= data_n;
      rd_err_o  <= err_n;
    end
  end
endmodule

// File: rtl/dual_lane_parity.sv
module dual_lane_parity
  import dual_lane_parity_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DATA_W = 8,
  localparam int WORD_W = LANES * (DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreset_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_data_o,
  input  logic              rd_en_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [LANES-1:0]  rd_err_o
);
  mode_t mode_q;
  logic  mr_first;

  dlp_mode_reg #(.WORD_W(WORD_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .mreset_i(mreset_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .mode_o(mode_q), .mr_first_o(mr_first)
  );

  dlp_wr_stage #(.LANES(LANES), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .mreset_i(mreset_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
  );

  dlp_rd_stage #(.LANES(LANES), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .mreset_i(mreset_i),
    .mr_first_i(mr_first), .rd_en_i(rd_en_i), .rd_data_i(rd_data_i),
    .rd_data_o(rd_data_o), .rd_err_o(rd_err_o)
  );
endmodule

// File: rtl/dual_lane_parity_chk.sv
module dual_lane_parity_chk
  import dual_lane_parity_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mreset_i,
  input logic              wr_en_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic              wr_en_o,
  input logic [WORD_W-1:0] wr_data_o,
  input logic              rd_en_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [LANES-1:0]  rd_err_o,
  input mode_t             mode_q
);
  // R2: nothing reaches storage while master reset is held
  a_r2_no_store_in_mr: assert property (@(posedge clk) disable iff (!rst_n)
    mreset_i |=> !wr_en_o);

  // R4: write passes unchanged when parity is off
  a_r4_wr_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !mreset_i && !mode_q.en) |=>
      (wr_en_o && wr_data_o == $past(wr_data_i)));

  // R5/R7: generated low lane obeys the selected sense
  a_r5_gen_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !mreset_i && mode_q.en && !mode_q.chk) |=>
      ((^wr_data_o[8:0]) == $past(mode_q.odd)));

  // R6: no error flagged outside check mode
  a_r6_err_only_check: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !mreset_i && !(mode_q.en && mode_q.chk)) |=> (rd_err_o == '0));

  // R9: idle read side holds its output
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && !mreset_i) |=> ($stable(rd_data_o) && $stable(rd_err_o)));

  // R8: programming readback shows only the mode field
  a_r8_prog_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mreset_i && rd_en_i) |=> (rd_data_o[WORD_W-4:0] == '0 && rd_err_o == '0));
endmodule

bind dual_lane_parity dual_lane_parity_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mreset_i(mreset_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
  .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_err_o(rd_err_o), .mode_q(mode_q)
);

// File: tb/dual_lane_parity_tb.sv
module dual_lane_parity_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mreset_i;
  logic        wr_en_i;
  logic [17:0] wr_data_i;
  logic        wr_en_o;
  logic [17:0] wr_data_o;
  logic        rd_en_i;
  logic [17:0] rd_data_i;
  logic [17:0] rd_data_o;
  logic [1:0]  rd_err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dual_lane_parity u_dut (
    .clk(clk), .rst_n(rst_n), .mreset_i(mreset_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .rd_en_i(rd_en_i), .rd_data_i(rd_data_i), .rd_data_o(rd_data_o),
    .rd_err_o(rd_err_o)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] gen_word(input logic [17:0] w, input logic odd);
    logic [17:0] r = w;
    r[8]  = ^w[7:0] ^ odd;
    r[17] = ^w[16:9] ^ odd;
    return r;
  endfunction

  function automatic logic [1:0] err_of(input logic [17:0] w, input logic odd);
    return {(^w[17:9]) ^ odd, (^w[8:0]) ^ odd};
  endfunction

  task automatic idle();
    mreset_i = 0; wr_en_i = 0; rd_en_i = 0;
  endtask

  task automatic program_mode(input logic [2:0] m);
    mreset_i = 1; wr_en_i = 1; rd_en_i = 0; wr_data_i = {m, 15'h1234};
    step();
    chk("R2 no store", {19'd0, wr_en_o}, 20'd0);
    wr_en_i = 0; step();
    idle(); step();
  endtask

  task automatic do_write(input logic [17:0] w);
    wr_en_i = 1; wr_data_i = w; step(); wr_en_i = 0;
  endtask

  task automatic do_read(input logic [17:0] w);
    rd_en_i = 1; rd_data_i = w; step(); rd_en_i = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); wr_data_i = '0; rd_data_i = '0;
    step(); step();
    rst_n = 1; step();
    chk("R1 wr_en", {19'd0, wr_en_o}, 20'd0);
    chk("R1 rd_data", {2'd0, rd_data_o}, 20'd0);
    chk("R1 rd_err", {18'd0, rd_err_o}, 20'd0);
    mreset_i = 1; rd_en_i = 1; step(); idle();
    chk("R1 mode off", {2'd0, rd_data_o}, 20'd0);
  endtask

  task automatic t_passthru();
    do_write(18'h2_A5C3);
    chk("R4 wr_en", {19'd0, wr_en_o}, 20'd1);
    chk("R4 wr data", {2'd0, wr_data_o}, {2'd0, 18'h2_A5C3});
    do_read(18'h1_0001);
    chk("R4 rd data", {2'd0, rd_data_o}, {2'd0, 18'h1_0001});
    chk("R4 rd err", {18'd0, rd_err_o}, 20'd0);
  endtask

  task automatic t_generate(input logic odd);
    logic [17:0] w [3] = '{18'h0_0000, 18'h3_FFFF, 18'h1_2E57};
    program_mode({1'b1, 1'b0, odd});
    foreach (w[i]) begin
      do_write(w[i]);
      chk(odd ? "R5 R7 gen odd" : "R5 R7 gen even", {2'd0, wr_data_o},
          {2'd0, gen_word(w[i], odd)});
    end
    do_read(18'h0_0001);
    chk("R6 no err in gen", {18'd0, rd_err_o}, 20'd0);
  endtask

  task automatic t_check(input logic odd);
    logic [17:0] good = gen_word(18'h0_9A3C, odd);
    logic [17:0] w [4];
    w[0] = good; w[1] = good ^ 18'h0_0004; w[2] = good ^ 18'h0_0400; w[3] = good ^ 18'h0_0201;
    program_mode({1'b1, 1'b1, odd});
    do_write(18'h0_0001);
    chk("R4 wr unchanged in check", {2'd0, wr_data_o}, {2'd0, 18'h0_0001});
    foreach (w[i]) begin
      do_read(w[i]);
      chk("R6 data", {2'd0, rd_data_o}, {2'd0, w[i]});
      chk(odd ? "R6 R7 err odd" : "R6 R7 err even", {18'd0, rd_err_o},
          {18'd0, err_of(w[i], odd)});
    end
  endtask

  task automatic t_hold();
    logic [17:0] bw = gen_word(18'h0_0F00, 1'b0) ^ 18'h0_0200;
    program_mode(3'b110);
    do_read(bw);
    rd_data_i = 18'h3_FFFF; step(); step();
    chk("R9 data hold", {2'd0, rd_data_o}, {2'd0, bw});
    chk("R9 err hold", {18'd0, rd_err_o}, 20'd2);
  endtask

  task automatic t_prog_read();
    program_mode(3'b101);
    mreset_i = 1; rd_en_i = 1; rd_data_i = 18'h3_FFFF; step();
    chk("R8 readback", {2'd0, rd_data_o}, {2'd0, 3'b101, 15'd0});
    idle(); step();
  endtask

  task automatic t_mr_clear();
    program_mode(3'b111);
    do_read(18'h0_0000);
    chk("R10 pre err", {18'd0, rd_err_o}, 20'd3);
    mreset_i = 1; step();
    chk("R10 data clr", {2'd0, rd_data_o}, 20'd0);
    chk("R10 err clr", {18'd0, rd_err_o}, 20'd0);
    idle(); step();
    do_read(18'h0_0000);
    chk("R3 bare mr disables check", {18'd0, rd_err_o}, 20'd0);
    mreset_i = 1; rd_en_i = 1; step(); idle(); step();
    chk("R3 mode cleared", {2'd0, rd_data_o}, 20'd0);
  endtask

  initial begin
    t_reset();
    t_passthru();
    t_generate(1'b0);
    t_generate(1'b1);
    t_check(1'b0);
    t_check(1'b1);
    t_hold();
    t_prog_read();
    t_mr_clear();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule